// File: doc/BRIEF.md
# Packed Vector Floating-Point Minimum-Number Unit

This block takes two 128-bit packed operands and a 32-bit instruction word. It returns, lane by lane, the smaller of each pair of floating-point elements. The instruction word chooses the lane format (16-bit half, 32-bit single or 64-bit double) and the vector width (64 or 128 bits). Patterns that do not encode this operation, and the reserved pairing of doubles with a 64-bit vector, are reported as undefined.

NaN handling follows the IEEE minimumNumber rules. A quiet NaN gives way to a numeric partner. A signalling NaN produces the default quiet NaN and an invalid-operation exception. Negative zero orders below positive zero.

An invalid-operation exception does one of two things. If the trap enable is low, it sets a sticky flag that is cleared only by reset. If the trap enable is high, it raises a one-cycle trap pulse instead. Work is started by an issue strobe, and all outputs are registered one clock later. The datapath is a single registered stage, so there is no state machine: the only sequencing is the issue-to-done pipeline register.

Top module: `vec_fmin_unit`

## Requirements
- R1: An instruction is recognised only when bit 31 is 0, bits 29:24 are 001110 and bit 21 is 1, and one of these also holds:
  - the half class: bits 23:22 = 11 and bits 15:10 = 000001;
  - the single/double class: bit 23 = 1 and bits 15:10 = 110001.
  Any other word sets `undef_o`.
- R2: A half-class instruction sets `undef_o` when `fp16_en_i` is 0.
- R3: In the single/double class, bit 22 selects the element size: 0 gives 32 bits and 1 gives 64 bits. Bit 30 selects the vector width: 0 gives 64 bits and 1 gives 128 bits. Bit 22 = 1 with bit 30 = 0 is reserved and sets `undef_o`.
- R4: An undefined instruction writes zero to `res_o`, raises no trap and leaves the sticky flag unchanged.
- R5: Each lane returns the smaller of its two numeric operands under sign-magnitude ordering: with both operands negative, the larger magnitude wins. Lane i of the result occupies the same bit positions as lane i of the sources.
- R6: Negative zero is smaller than positive zero, so a lane holding +0 and −0 returns −0.
- R7: A lane with exactly one quiet NaN (quiet bit = fraction MSB = 1) returns the other operand. A lane with two quiet NaNs returns the default quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other bits 0. These are 0x7E00, 0x7FC00000 and 0x7FF8000000000000.
- R8: A lane with a signalling NaN in either operand returns the default quiet NaN and raises invalid-operation.
- R9: If any active lane raises invalid-operation, the result depends on `inv_trap_en_i`. With the enable low, `inv_sticky_o` is set and holds until reset. With the enable high, `inv_trap_o` pulses for one cycle and the sticky flag is unchanged.
- R10: In 64-bit mode, `res_o[127:64]` is zero, and lanes in the upper half never raise invalid-operation.
- R11: All outputs are 0 after reset. `res_o`, `undef_o` and `inv_trap_o` reflect an issue on the clock edge after `issue_i`, and `done_o` pulses at that edge. Without an issue, `res_o` holds its value and the pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Start one operation this cycle |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 128 | First packed operand |
| opb_i | input | 128 | Second packed operand |
| fp16_en_i | input | 1 | Half-precision support enable |
| inv_trap_en_i | input | 1 | Trap enable for invalid-operation |
| res_o | output | 128 | Packed result |
| done_o | output | 1 | Result valid pulse |
| undef_o | output | 1 | Undefined-instruction pulse |
| inv_trap_o | output | 1 | Invalid-operation trap pulse |
| inv_sticky_o | output | 1 | Accumulated invalid-operation flag |

## Verification
Two functions can meet in one issue: a signalling NaN raising invalid-operation, and the 64-bit mode masking of upper lanes. The bench provokes this by placing signalling NaNs only in the upper half of a narrow operation. It then judges that the sticky flag and the trap both stay quiet while the lower lanes still carry ordinary minima. A second collision is a reserved or undefined word carrying signalling-NaN operands. There the undefined report must win: a zero result and no exception. Random runs mix both situations with either trap setting and compare against a lane-by-lane bench model.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } lane_fmt_e;

    localparam int H_EXP = 5;
    localparam int H_FRAC = 10;
    localparam int S_EXP = 8;
    localparam int S_FRAC = 23;
    localparam int D_EXP = 11;
    localparam int D_FRAC = 52;
endpackage

// File: rtl/vfm_decode.sv
module vfm_decode
    import vfm_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        fp16_en_i,
    output lane_fmt_e   fmt_o,
    output logic        wide_o,
    output logic        undef_o
);
    logic base_ok;
    logic is_half;
    logic is_sd;
    logic reserved_combo;
    logic unused_reg_fields;

    assign base_ok = !instr_i[31] && (instr_i[29:24] == 6'b001110) && instr_i[21];
    assign is_half = base_ok && (instr_i[23:22] == 2'b11) && (instr_i[15:10] == 6'b000001);
    assign is_sd   = base_ok && instr_i[23] && (instr_i[15:10] == 6'b110001);
    assign reserved_combo = instr_i[22] && !instr_i[30];

    // Register-number fields play no part in the datapath.
    assign unused_reg_fields = ^{instr_i[20:16], instr_i[9:0]};

    always_comb begin
        fmt_o = FMT_SINGLE;
        if (is_half) begin
            fmt_o = FMT_HALF;
        end else if (instr_i[22]) begin
            fmt_o = FMT_DOUBLE;
        end
    end

    assign wide_o  = instr_i[30];
    assign undef_o = !((is_half && fp16_en_i) || (is_sd && !reserved_combo));
endmodule

// File: rtl/vfm_lane.sv
module vfm_lane #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int EW    = 1 + EXP_W + FRAC_W
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] y_o,
    output logic          inv_o
);
    localparam logic [EW-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, b_nan, a_snan, b_snan, a_lt_b;

    assign a_nan  = (&a_i[EW-2:FRAC_W]) && (|a_i[FRAC_W-1:0]);
    assign b_nan  = (&b_i[EW-2:FRAC_W]) && (|b_i[FRAC_W-1:0]);
    assign a_snan = a_nan && !a_i[FRAC_W-1];
    assign b_snan = b_nan && !b_i[FRAC_W-1];

    // Sign-magnitude order: a differing sign decides (so -0 < +0),
    // and among negatives the larger magnitude is the smaller value.
    always_comb begin
        if (a_i[EW-1] != b_i[EW-1]) begin
            a_lt_b = a_i[EW-1];
        end else if (a_i[EW-1]) begin
            a_lt_b = a_i[EW-2:0] > b_i[EW-2:0];
        end else begin
            a_lt_b = a_i[EW-2:0] < b_i[EW-2:0];
        end
    end

    always_comb begin
        inv_o = a_snan || b_snan;
        if (a_snan || b_snan || (a_nan && b_nan)) begin
            y_o = DEF_QNAN;
        end else if (a_nan) begin
            y_o = b_i;
        end else if (b_nan) begin
            y_o = a_i;
        end else begin
            y_o = a_lt_b ? a_i : b_i;
        end
    end
endmodule

// File: rtl/vfm_lane_array.sv
module vfm_lane_array #(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int EW    = 1 + EXP_W + FRAC_W,
    localparam int NL    = VEC_W / EW
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] y_o,
    output logic [NL-1:0]    inv_o
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        vfm_lane #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_lane (
            .a_i  (a_i[g*EW +: EW]),
            .b_i  (b_i[g*EW +: EW]),
            .y_o  (y_o[g*EW +: EW]),
            .inv_o(inv_o[g])
        );
    end
endmodule

// File: rtl/vec_fmin_unit.sv
module vec_fmin_unit
    import vfm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [31:0]      instr_i,
    input  logic [VEC_W-1:0] opa_i,
    input  logic [VEC_W-1:0] opb_i,
    input  logic             fp16_en_i,
    input  logic             inv_trap_en_i,
    output logic [VEC_W-1:0] res_o,
    output logic             done_o,
    output logic             undef_o,
    output logic             inv_trap_o,
    output logic             inv_sticky_o
);
    localparam int HALF_W = VEC_W / 2;
    localparam int NH = VEC_W / (1 + H_EXP + H_FRAC);
    localparam int NS = VEC_W / (1 + S_EXP + S_FRAC);
    localparam int ND = VEC_W / (1 + D_EXP + D_FRAC);

    lane_fmt_e dec_fmt;
    logic      dec_wide, dec_undef;

    vfm_decode u_dec (
        .instr_i  (instr_i),
        .fp16_en_i(fp16_en_i),
        .fmt_o    (dec_fmt),
        .wide_o   (dec_wide),
        .undef_o  (dec_undef)
    );

    logic [VEC_W-1:0] h_res, s_res, d_res;
    logic [NH-1:0]    h_inv;
    logic [NS-1:0]    s_inv;
    logic [ND-1:0]    d_inv;

    vfm_lane_array #(.VEC_W(VEC_W), .EXP_W(H_EXP), .FRAC_W(H_FRAC)) u_half (
        .a_i(opa_i), .b_i(opb_i), .y_o(h_res), .inv_o(h_inv));
    vfm_lane_array #(.VEC_W(VEC_W), .EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_single (
        .a_i(opa_i), .b_i(opb_i), .y_o(s_res), .inv_o(s_inv));
    vfm_lane_array #(.VEC_W(VEC_W), .EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_double (
        .a_i(opa_i), .b_i(opb_i), .y_o(d_res), .inv_o(d_inv));

    logic [VEC_W-1:0] sel_res;
    logic             sel_inv;

    // Pick the lane array for the format; only active lanes may raise invalid.
    always_comb begin
        sel_res = '0;
        sel_inv = 1'b0;
        unique case (dec_fmt)
            FMT_HALF: begin
                sel_res = h_res;
                for (int i = 0; i < NH; i++)
                    if (dec_wide || i < NH / 2) sel_inv = sel_inv | h_inv[i];
            end
            FMT_SINGLE: begin
                sel_res = s_res;
                for (int i = 0; i < NS; i++)
                    if (dec_wide || i < NS / 2) sel_inv = sel_inv | s_inv[i];
            end
            FMT_DOUBLE: begin
                sel_res = d_res;
                for (int i = 0; i < ND; i++)
                    if (dec_wide || i < ND / 2) sel_inv = sel_inv | d_inv[i];
            end
            default: begin
                sel_res = '0;
                sel_inv = 1'b0;
            end
        endcase
        if (!dec_wide) sel_res[VEC_W-1:HALF_W] = '0;
    end

    logic raise_inv;
    assign raise_inv = issue_i && !dec_undef && sel_inv;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            res_o        <= '0;
            done_o       <= 1'b0;
            undef_o      <= 1'b0;
            inv_trap_o   <= 1'b0;
            inv_sticky_o <= 1'b0;
        end else begin
            done_o     <= issue_i;
            undef_o    <= issue_i && dec_undef;
            inv_trap_o <= raise_inv && inv_trap_en_i;
            if (issue_i) res_o <= dec_undef ? '0 : sel_res;
            if (raise_inv && !inv_trap_en_i) inv_sticky_o <= 1'b1;
        end
    end

    AST_RESERVED_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_n)
        issue_i && instr_i[22] && !instr_i[30] && instr_i[15:10] == 6'b110001 |=> undef_o) // R3
        else $error("reserved combination not flagged");
    AST_UNDEF_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_n)
        undef_o |-> res_o == '0) // R4
        else $error("undefined op left a result");
    AST_UNDEF_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_n)
        undef_o |-> !inv_trap_o) // R4
        else $error("undefined op trapped");
    AST_STICKY_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
        !$fell(inv_sticky_o)) // R9
        else $error("sticky flag cleared");
    AST_TRAP_KEEPS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
        inv_trap_o |-> $stable(inv_sticky_o)) // R9
        else $error("trap changed sticky flag");
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
        issue_i && !instr_i[30] |=> res_o[VEC_W-1:HALF_W] == '0) // R10
        else $error("upper half written in narrow mode");
    AST_DONE_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_n)
        issue_i |=> done_o) // R11
        else $error("done missing");
endmodule

// File: tb/tb_vec_fmin_unit.sv
module tb_vec_fmin_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] opa = '0, opb = '0;
    logic         fp16_en = 1'b1, trap_en = 1'b0;
    logic [127:0] res;
    logic         done, undef, trap, sticky;

    int  nchk = 0, nerr = 0;
    bit  m_sticky = 1'b0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    vec_fmin_unit dut (
        .clk_i(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr),
        .opa_i(opa), .opb_i(opb), .fp16_en_i(fp16_en), .inv_trap_en_i(trap_en),
        .res_o(res), .done_o(done), .undef_o(undef), .inv_trap_o(trap),
        .inv_sticky_o(sticky)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exv);
        end
    endtask

    function automatic int exp_w(input int ew);
        return (ew == 16) ? 5 : ((ew == 32) ? 8 : 11);
    endfunction

    function automatic logic [63:0] def_qnan(input int ew);
        int fw = ew - 1 - exp_w(ew);
        return ((((64'd1 << exp_w(ew)) - 1) << fw) | (64'd1 << (fw - 1)));
    endfunction

    // Returns {invalid, result} for one lane.
    function automatic logic [64:0] ref_min(input int ew, input logic [63:0] a, input logic [63:0] b);
        int fw = ew - 1 - exp_w(ew);
        logic [63:0] fmask = (64'd1 << fw) - 1;
        logic [63:0] emask = ((64'd1 << exp_w(ew)) - 1) << fw;
        logic [63:0] smask = 64'd1 << (ew - 1);
        logic [63:0] mmask = smask - 1;
        bit an = ((a & emask) == emask) && ((a & fmask) != 0);
        bit bn = ((b & emask) == emask) && ((b & fmask) != 0);
        bit asn = an && (((a >> (fw - 1)) & 64'd1) == 0);
        bit bsn = bn && (((b >> (fw - 1)) & 64'd1) == 0);
        bit sa = (a & smask) != 0;
        bit sb = (b & smask) != 0;
        bit lt;
        if (asn || bsn) return {1'b1, def_qnan(ew)};
        if (an && bn) return {1'b0, def_qnan(ew)};
        if (an) return {1'b0, b};
        if (bn) return {1'b0, a};
        if (sa != sb) lt = sa;
        else if (sa) lt = (a & mmask) > (b & mmask);
        else lt = (a & mmask) < (b & mmask);
        return {1'b0, lt ? a : b};
    endfunction

    function automatic void ref_vec(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                                    input logic h_en, output logic [127:0] r, output logic und,
                                    output logic inv);
        bit base = (w[31] == 1'b0) && (w[29:24] == 6'b001110) && w[21];
        bit hcls = base && (w[23:22] == 2'b11) && (w[15:10] == 6'b000001);
        bit scls = base && w[23] && (w[15:10] == 6'b110001);
        int ew = hcls ? 16 : (w[22] ? 64 : 32);
        int nl = (w[30] ? 128 : 64) / ew;
        logic [63:0] lmask = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        r = '0;
        inv = 1'b0;
        und = !((hcls && h_en) || (scls && !(w[22] && !w[30])));
        if (und) return;
        for (int e = 0; e < nl; e++) begin
            logic [63:0] ea = 64'(a >> (e * ew)) & lmask;
            logic [63:0] eb = 64'(b >> (e * ew)) & lmask;
            logic [64:0] o = ref_min(ew, ea, eb);
            inv = inv | o[64];
            r = r | ({64'd0, o[63:0]} << (e * ew));
        end
    endfunction

    function automatic logic [31:0] mk_instr(input bit half, input bit q, input bit sz);
        logic [31:0] w = $urandom;
        w[31] = 1'b0;
        w[30] = q;
        w[29:24] = 6'b001110;
        w[21] = 1'b1;
        if (half) begin
            w[23:22] = 2'b11;
            w[15:10] = 6'b000001;
        end else begin
            w[23] = 1'b1;
            w[22] = sz;
            w[15:10] = 6'b110001;
        end
        return w;
    endfunction

    function automatic logic [63:0] rnd_elem(input int ew);
        int fw = ew - 1 - exp_w(ew);
        logic [63:0] fmask = (64'd1 << fw) - 1;
        logic [63:0] emask = ((64'd1 << exp_w(ew)) - 1) << fw;
        logic [63:0] smask = 64'd1 << (ew - 1);
        logic [63:0] lmask = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        logic [63:0] r = {$urandom, $urandom};
        case ($urandom % 8)
            0: return 64'd0;
            1: return smask;
            2: return emask | (64'd1 << (fw - 1)) | (r & fmask) | (r & smask);
            3: return emask | (r & (fmask >> 1)) | 64'd1;
            4: return emask | (r & smask);
            default: return r & lmask;
        endcase
    endfunction

    function automatic logic [127:0] rnd_vec(input int ew);
        logic [127:0] v = '0;
        for (int e = 0; e < 128 / ew; e++) v = v | ({64'd0, rnd_elem(ew)} << (e * ew));
        return v;
    endfunction

    // Called at a falling edge; leaves at the next falling edge.
    task automatic apply(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                         input logic h_en, input logic t_en, input string tag);
        logic [127:0] er;
        logic eu, einv;
        bit etrap;
        ref_vec(w, a, b, h_en, er, eu, einv);
        etrap = !eu && einv && t_en;
        if (!eu && einv && !t_en) m_sticky = 1'b1;
        instr = w; opa = a; opb = b; fp16_en = h_en; trap_en = t_en; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk(res == er, {tag, " result"}, res, er);
        chk(undef == eu, {tag, " undef"}, 128'(undef), 128'(eu));
        chk(trap == etrap, {tag, " R9 trap"}, 128'(trap), 128'(etrap));
        chk(sticky == m_sticky, {tag, " R9 sticky"}, 128'(sticky), 128'(m_sticky));
        chk(done == 1'b1, {tag, " R11 done"}, 128'(done), 128'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        issue = 1'b0;
        m_sticky = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [127:0] hold;
        logic [31:0]  w;
        void'($urandom(32'd20240611));
        do_reset();
        // R11: reset state
        chk(res == '0 && !done && !undef && !trap && !sticky, "R11 reset", res, '0);

        // R5: half lanes, mixed positives and negatives (-1 vs -2 gives -2)
        apply(mk_instr(1, 1, 0), {64'h0, 32'h4000_3C00, 32'hBC00_3C00},
              {64'h0, 32'h3C00_4000, 32'hC000_4000}, 1, 0, "R5 half");
        chk(res[31:16] == 16'hC000, "R5 neg magnitude", 128'(res[31:16]), 128'hC000);
        // R6: -0 versus +0 in single lanes
        apply(mk_instr(0, 1, 0), {32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0},
              {32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8000_0000}, 1, 0, "R6 zero");
        chk(res == {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
            "R6 literal", res, {4{32'h8000_0000}});
        // R7: one quiet NaN yields numeric operand; two yield default NaN
        apply(mk_instr(0, 1, 1), {64'h7FF8_0000_0000_1234, 64'h7FF8_0000_0000_0001},
              {64'h3FF0_0000_0000_0000, 64'hFFF8_0000_0000_0000}, 1, 0, "R7 double");
        chk(res == {64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000}, "R7 literal",
            res, {64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000});
        // R8/R9: signalling NaN, trap disabled sets sticky
        apply(mk_instr(0, 1, 0), {96'h0, 32'h7F80_0001}, {96'h0, 32'h3F80_0000}, 1, 0, "R8 snan sticky");
        chk(res[31:0] == 32'h7FC0_0000, "R8 default nan", 128'(res[31:0]), 128'h7FC0_0000);
        // R11: idle cycle holds result, no pulses
        hold = res;
        @(negedge clk);
        chk(res == hold && !done && !trap && !undef, "R11 idle hold", res, hold);
        // R9: trap enabled, sticky unaffected (sticky already 1, so reset first)
        do_reset();
        apply(mk_instr(1, 1, 0), {112'h0, 16'h7C01}, {112'h0, 16'h0001}, 1, 1, "R9 trap");
        // R10: narrow mode, signalling NaNs only in upper lanes
        apply(mk_instr(1, 0, 0), {64'h7C01_7C01_7C01_7C01, 64'h3C00_BC00_0000_8000},
              {64'h7C01_7C01_7C01_7C01, 64'h4000_C000_8000_0000}, 1, 0, "R10 narrow");
        chk(res[127:64] == '0 && !sticky, "R10 upper masked", res, '0);
        // R1: bad fixed bit
        w = mk_instr(0, 1, 0); w[31] = 1'b1;
        apply(w, '1, '1, 1, 0, "R1 bad bit31");
        w = mk_instr(0, 1, 0); w[15:10] = 6'b110101;
        apply(w, '0, '0, 1, 0, "R1 bad opcode");
        // R2: half disabled
        apply(mk_instr(1, 1, 0), {8{16'h3C00}}, {8{16'h4000}}, 0, 0, "R2 fp16 off");
        // R3/R4: reserved doubles in 64-bit vector, with snan operands
        apply(mk_instr(0, 1, 1), {2{64'h4000_0000_0000_0000}}, {2{64'h3FF0_0000_0000_0000}}, 1, 0, "R3 wide double");
        apply(mk_instr(0, 0, 1), {2{64'h7FF0_0000_0000_0001}}, '0, 1, 1, "R4 reserved");
        chk(res == '0 && !trap && !sticky, "R4 zero result", res, '0);
        // R3: single narrow
        apply(mk_instr(0, 0, 0), {4{32'hC000_0000}}, {4{32'hBF80_0000}}, 1, 0, "R3 single narrow");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int k = $urandom % 3;
            int ew = (k == 0) ? 16 : ((k == 1) ? 32 : 64);
            bit q = $urandom % 4 != 0;
            w = mk_instr(k == 0, q, k == 2);
            if ($urandom % 12 == 0) w[$urandom % 32] ^= 1'b1;
            apply(w, rnd_vec(ew), rnd_vec(ew), ($urandom % 8) != 0, ($urandom % 3) == 0, "R5 random");
            if ($urandom % 50 == 0) do_reset();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule